// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Clock

This block keeps a free-running time-of-day value for precision time protocol work. The time is held as a 64-bit whole-nanosecond count with a 32-bit fraction of a nanosecond below it. While the clock is running, every core clock cycle adds a per-cycle step to the combined 96-bit value. The step is in 32.32 fixed point: whole nanoseconds in the upper half and fractions of a nanosecond in the lower half. Because the fraction is kept, the clock can run at a period that is not a whole number of nanoseconds. Software trims the frequency in parts-per-billion steps by rewriting the step value.

Software reaches the block through a simple synchronous port that has a byte address, write data, a write strobe and registered read data. Four 64-bit registers are mapped:

- a control word whose bit 0 starts and stops the clock;
- the fractional time;
- the whole-nanosecond time;
- the step.

The nominal step is (10^9 << 32) / f, where f is the core clock frequency in Hz. The reset value of the step is derived from a frequency parameter.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the control word reads 0, both time registers read 0, and the step register reads (10^9 << 32) / CLK_HZ. With the default 800 MHz this is 0x0000_0001_4000_0000.
- R2: The control word is at byte offset 0xF00. Only bit 0 (run) is stored. All other bits are ignored on write and read as 0.
- R3: While run is 1, each clock cycle adds the step to the 96-bit time {whole, fraction}. The upper 32 step bits align with whole-nanosecond bit 0, and the lower 32 bits align with the fraction. A carry out of the fraction increments the whole count in the same cycle.
- R4: While run is 0, neither the whole nor the fractional time changes.
- R5: The time wraps modulo 2^96, so the whole count wraps modulo 2^64.
- R6: A write to the whole-nanosecond register (offset 0xF10) or the fractional register (offset 0xF08) loads that value. It replaces the step addition in that cycle, and the other time register holds its value. The fraction occupies write-data bits 31:0; bits 63:32 of the fractional register read as 0.
- R7: A write to the step register (offset 0xF18) is used from the next cycle on. The cycle of the write still adds the old step, and the accumulated time is not disturbed.
- R8: Read data is registered. The value of the register addressed in one cycle appears on the read data one clock edge later, and reflects the state before that edge.
- R9: Any address other than the four listed reads as 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 64 | Registered read data for the previous cycle's address |

## Verification
A register write takes effect at the edge where the strobe is sampled. A time step that is enabled there first adds at the following edge, and a step change is first used one edge later. The bench's tasks each consume exactly one clock edge, so the number of additions in a run equals the number of edges from enable to disable. The bench therefore expects start plus that count times the step. Read data is sampled at the falling edge after the capturing edge, and one check confirms the old value is still present before that edge.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 64;
    localparam int FRAC_W  = 32;
    localparam int WHOLE_W = 64;
    localparam int TOD_W   = WHOLE_W + FRAC_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_SUBNS = 12'hF08;
    localparam logic [ADDR_W-1:0] OFS_NS    = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_STEP  = 12'hF18;

    typedef struct packed {
        logic [WHOLE_W-1:0] ns;
        logic [FRAC_W-1:0]  sub;
    } tod_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_SUBNS,
        SEL_NS,
        SEL_STEP
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_SUBNS: return SEL_SUBNS;
            OFS_NS:    return SEL_NS;
            OFS_STEP:  return SEL_STEP;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] nominal_step(input longint unsigned hz);
        logic [DATA_W-1:0] num;
        num = 64'd1_000_000_000 << FRAC_W;
        return num / DATA_W'(hz);
    endfunction

endpackage

// File: rtl/ptp_ctrl_regs.sv
module ptp_ctrl_regs
    import ptp_tod_pkg::*;
#(
    parameter logic [DATA_W-1:0] STEP_RST = 64'h0000_0001_4000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              run_o,
    output logic [DATA_W-1:0] step_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o  <= 1'b0;
            step_o <= STEP_RST;
        end else if (we) begin
            if (sel == SEL_CTRL) run_o  <= wdata[0];
            if (sel == SEL_STEP) step_o <= wdata;
        end
    end

endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DATA_W-1:0] step,
    input  logic              ld_ns,
    input  logic              ld_sub,
    input  logic [DATA_W-1:0] wdata,
    output tod_t              tod_o
);

    localparam int PAD_W = TOD_W - DATA_W;

    tod_t tod_next;

    always_comb begin
        tod_next = tod_o;
        if (ld_ns || ld_sub) begin
            if (ld_ns)  tod_next.ns  = wdata[WHOLE_W-1:0];
            if (ld_sub) tod_next.sub = wdata[FRAC_W-1:0];
        end else if (run) begin
            tod_next = tod_o + {{PAD_W{1'b0}}, step};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod_o <= '0;
        else     tod_o <= tod_next;
    end

endmodule

// File: rtl/ptp_rd_port.sv
module ptp_rd_port
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              run,
    input  logic [DATA_W-1:0] step,
    input  tod_t              tod,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int SUB_PAD = DATA_W - FRAC_W;

    logic [DATA_W-1:0] mux;

    always_comb begin
        case (sel)
            SEL_CTRL:  mux = {{(DATA_W-1){1'b0}}, run};
            SEL_SUBNS: mux = {{SUB_PAD{1'b0}}, tod.sub};
            SEL_NS:    mux = tod.ns;
            SEL_STEP:  mux = step;
            default:   mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= mux;
    end

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd800_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic              bus_we,
    output logic [63:0]       bus_rdata
);

    localparam logic [DATA_W-1:0] STEP_NOM = nominal_step(CLK_HZ);

    reg_sel_e          sel;
    logic              run_en;
    logic [DATA_W-1:0] step_q;
    tod_t              tod_q;
    logic              ld_ns;
    logic              ld_sub;

    assign sel    = decode_addr(bus_addr);
    assign ld_ns  = bus_we && (sel == SEL_NS);
    assign ld_sub = bus_we && (sel == SEL_SUBNS);

    ptp_ctrl_regs #(.STEP_RST(STEP_NOM)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .run_o  (run_en),
        .step_o (step_q)
    );

    ptp_tod_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .run    (run_en),
        .step   (step_q),
        .ld_ns  (ld_ns),
        .ld_sub (ld_sub),
        .wdata  (bus_wdata),
        .tod_o  (tod_q)
    );

    ptp_rd_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .run     (run_en),
        .step    (step_q),
        .tod     (tod_q),
        .rdata_o (bus_rdata)
    );

endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
    import ptp_tod_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 64'd800_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              run,
    input logic [DATA_W-1:0] step,
    input logic [TOD_W-1:0]  tod
);

    localparam logic [DATA_W-1:0] STEP_NOM = nominal_step(CLK_HZ);

    logic time_wr;
    logic mapped;
    assign time_wr = bus_we && (bus_addr == OFS_NS || bus_addr == OFS_SUBNS);
    assign mapped  = decode_addr(bus_addr) != SEL_NONE;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (step == STEP_NOM && !run && tod == '0)); // R1

    AST_RUN_ADDS_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !time_wr) |=> (tod == $past(tod) + {{(TOD_W-DATA_W){1'b0}}, $past(step)})); // R3

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run && !time_wr) |=> $stable(tod)); // R4

    AST_LOAD_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_NS) |=> (tod[TOD_W-1:FRAC_W] == $past(bus_wdata))); // R6

    AST_STEP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_STEP) |=> (step == $past(bus_wdata))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |=> (bus_rdata == '0)); // R9

endmodule

bind ptp_tod_clock ptp_tod_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .run       (run_en),
    .step      (step_q),
    .tod       (tod_q)
);

// File: tb/tb_ptp_tod_clock.sv
`timescale 1ns/1ps
module tb_ptp_tod_clock;

    localparam logic [11:0] A_CTRL  = 12'hF00;
    localparam logic [11:0] A_SUBNS = 12'hF08;
    localparam logic [11:0] A_NS    = 12'hF10;
    localparam logic [11:0] A_STEP  = 12'hF18;
    localparam logic [63:0] NOM     = 64'h0000_0001_4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [63:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptp_tod_clock dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // each task starts just after a falling edge and consumes one rising edge
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic run_for(input int k);
        wr(A_CTRL, 64'd1);
        for (int i = 1; i < k; i++) idle();
        wr(A_CTRL, 64'd0);
    endtask

    task automatic rd_time(output logic [95:0] t);
        logic [63:0] n, s;
        rd(A_NS, n);
        rd(A_SUBNS, s);
        t = {n, s[31:0]};
    endtask

    task automatic set_time(input logic [63:0] n, input logic [31:0] s);
        wr(A_NS, n);
        wr(A_SUBNS, {32'd0, s});
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(A_CTRL, d);  chk("R1 ctrl", d, 64'd0);
        rd(A_NS, d);    chk("R1 ns", d, 64'd0);
        rd(A_SUBNS, d); chk("R1 subns", d, 64'd0);
        rd(A_STEP, d);  chk("R1 step", d, NOM);
        for (int i = 0; i < 6; i++) idle();
        rd(A_NS, d);    chk("R4 frozen after reset", d, 64'd0);
    endtask

    task automatic t_ctrl_bits();
        logic [63:0] d;
        wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(A_CTRL, d); chk("R2 upper ctrl bits ignored", d, 64'd0);
        wr(A_CTRL, 64'h8000_0000_0000_0001);
        rd(A_CTRL, d); chk("R2 run bit only", d, 64'd1);
        wr(A_CTRL, 64'd0);
    endtask

    task automatic t_run();
        logic [95:0] t;
        logic [95:0] exp;
        set_time(64'd1000, 32'd0);
        wr(A_STEP, NOM);
        run_for(10);
        rd_time(t);
        exp = {64'd1000, 32'd0} + 96'd10 * {32'd0, NOM};
        chk("R3 ns after 10 steps", t[95:32], exp[95:32]);
        chk("R3 fraction after 10 steps", {32'd0, t[31:0]}, {32'd0, exp[31:0]});
        chk("R3 value 1012.5ns", t[95:32], 64'd1012);
    endtask

    task automatic t_carry();
        logic [95:0] t;
        set_time(64'd7, 32'hFFFF_FFFF);
        wr(A_STEP, 64'd1);
        run_for(1);
        rd_time(t);
        chk("R3 fraction carry ns", t[95:32], 64'd8);
        chk("R3 fraction carry sub", {32'd0, t[31:0]}, 64'd0);
    endtask

    task automatic t_wrap();
        logic [95:0] t;
        set_time(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFF0);
        wr(A_STEP, 64'h20);
        run_for(1);
        rd_time(t);
        chk("R5 wrap ns", t[95:32], 64'd0);
        chk("R5 wrap sub", {32'd0, t[31:0]}, 64'h10);
    endtask

    task automatic t_hold();
        logic [95:0] a, b;
        set_time(64'd555, 32'h1234);
        wr(A_STEP, NOM);
        rd_time(a);
        for (int i = 0; i < 8; i++) idle();
        rd_time(b);
        chk("R4 ns held while stopped", b[95:32], a[95:32]);
        chk("R4 sub held while stopped", {32'd0, b[31:0]}, {32'd0, a[31:0]});
    endtask

    task automatic t_load();
        logic [95:0] t;
        logic [63:0] d;
        set_time(64'd100, 32'd0);
        wr(A_STEP, 64'h1_0000_0000);
        wr(A_CTRL, 64'd1);
        wr(A_NS, 64'd5000);
        wr(A_CTRL, 64'd0);
        rd_time(t);
        chk("R6 load overrides increment", t[95:32], 64'd5001);
        chk("R6 sub holds on ns load", {32'd0, t[31:0]}, 64'd0);
        wr(A_SUBNS, 64'hABCD_0000_1234_5678);
        rd(A_SUBNS, d);
        chk("R6 fraction width", d, 64'h0000_0000_1234_5678);
        rd(A_NS, d);
        chk("R6 ns holds on sub load", d, 64'd5001);
    endtask

    task automatic t_step_change();
        logic [95:0] t;
        logic [63:0] d;
        set_time(64'd0, 32'd0);
        wr(A_STEP, 64'h1_0000_0000);
        wr(A_CTRL, 64'd1);
        idle();
        wr(A_STEP, 64'h3_0000_0000);
        wr(A_CTRL, 64'd0);
        rd_time(t);
        chk("R7 new step from next cycle", t[95:32], 64'd5);
        chk("R7 fraction undisturbed", {32'd0, t[31:0]}, 64'd0);
        rd(A_STEP, d);
        chk("R7 step readback", d, 64'h3_0000_0000);
    endtask

    task automatic t_rd_latency();
        logic [63:0] d;
        set_time(64'hCAFE, 32'd0);
        wr(A_STEP, 64'h77);
        rd(A_NS, d);
        chk("R8 ns read", d, 64'hCAFE);
        bus_addr = A_STEP;
        #1;
        chk("R8 old data before edge", bus_rdata, 64'hCAFE);
        @(negedge clk);
        chk("R8 new data after edge", bus_rdata, 64'h77);
    endtask

    task automatic t_unmapped();
        logic [95:0] t;
        logic [63:0] d;
        set_time(64'd42, 32'd9);
        wr(A_STEP, 64'h5);
        wr(12'h008, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'hF20, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'hF04, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'hF20, d); chk("R9 unmapped read F20", d, 64'd0);
        rd(12'hF0C, d); chk("R9 unmapped read F0C", d, 64'd0);
        rd(A_CTRL, d);  chk("R9 ctrl untouched", d, 64'd0);
        rd(A_STEP, d);  chk("R9 step untouched", d, 64'h5);
        rd_time(t);
        chk("R9 ns untouched", t[95:32], 64'd42);
        chk("R9 sub untouched", {32'd0, t[31:0]}, 64'd9);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_bits();
        t_run();
        t_carry();
        t_wrap();
        t_hold();
        t_load();
        t_step_change();
        t_rd_latency();
        t_unmapped();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

endmodule